// File: doc/BRIEF.md
# Speculation Control Register Unit

This block sits inside a processor core model and answers model-specific register reads and writes for the speculation-mitigation controls. It keeps one persistent three-bit control register and accepts writes to two command registers that have no storage: each turns an accepted write of 1 into a single-cycle action pulse, one toward the branch predictor (a predictor barrier) and one toward the level-one data cache (a flush). A read-only capability word is returned on request. The unit also builds the feature bits that the identification instruction reports. Both the feature bits and the capability word come from static configuration inputs.

Every accepted write is ordered against the pipeline without serializing it. The unit raises a drain request and holds younger issue. It waits for the pipeline to report that older work has finished locally, then performs the write. For a command it also waits for the target unit's acknowledge. Only then does it respond and release issue. Reads and rejected writes answer one cycle after acceptance and never touch the pipeline. A request is taken only while the unit reports ready. The requester offers it for one cycle and waits for the response.

Top module: `spec_ctl_unit`

## Requirements
- R1: After reset ctrlBits is 0, reqReady is 1, and rspValid, drainReq, issueHold, barrierPulse and flushPulse are all 0.
- R2: idFeatWord carries featEn[0] at bit 26 (branch restriction with barrier), featEn[1] at bit 27 (per-thread predictor isolation), featEn[2] at bit 28 (data cache flush), featEn[3] at bit 29 (capability word present) and featEn[4] at bit 31 (store-bypass disable). Every other bit is 0.
- R3: A read of index 0x048, while at least one of featEn[0], featEn[1], featEn[4] is set, returns ctrlBits zero-extended on rspData with rspErr 0 in the cycle after acceptance, without raising drainReq.
- R4: A read of 0x10A returns capWord when featEn[3] is 1 and is an error otherwise. Reads of 0x049, 0x10B or any other index are errors. Every error response carries rspData 0.
- R5: A write to 0x048 whose set bits are all permitted (bit 0 needs featEn[0], bit 1 needs featEn[1], bit 2 needs featEn[4]) loads reqData[2:0] into ctrlBits and responds with rspErr 0 and rspData 0.
- R6: These writes answer with rspErr 1 in the cycle after acceptance: a write to the control register that sets a reserved bit (bit 3 and up) or a bit whose feature flag is clear, or that arrives while all three of its flags are clear; any write to 0x10A or to an unknown index; and a command write that sets a bit other than bit 0 or whose feature flag (featEn[0] for 0x049, featEn[2] for 0x10B) is clear. Such a write changes no state, raises no drainReq and emits no pulse.
- R7: From the cycle after a valid write is accepted, issueHold stays 1 until the response. drainReq stays 1 from that same cycle until pipeEmpty is seen. In the response cycle issueHold is 0 and reqReady is 1.
- R8: A write takes effect (ctrlBits change or a pulse) only after pipeEmpty has been sampled high while drainReq was high.
- R9: A valid write of 1 in bit 0 of 0x049 produces barrierPulse for exactly one cycle. The response follows the cycle after barrierAck is sampled.
- R10: A valid write of 1 in bit 0 of 0x10B produces flushPulse for exactly one cycle. The response follows the cycle after flushAck is sampled.
- R11: A valid write of 0 to either command register drains like any other write but emits no pulse and responds without waiting for an acknowledge.
- R12: A request offered while reqReady is 0 is ignored. It produces no response and does not change ctrlBits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| featEn | input | 5 | Static feature configuration (branch, thread, flush, capability, bypass) |
| capWord | input | 64 | Static capability word returned at 0x10A |
| idFeatWord | output | 32 | Feature bits for the identification output word |
| reqValid | input | 1 | Register request offered |
| reqWrite | input | 1 | 1 for write, 0 for read |
| reqIndex | input | 12 | Register index |
| reqData | input | 64 | Write data |
| reqReady | output | 1 | Unit idle and able to take a request |
| rspValid | output | 1 | One-cycle response strobe |
| rspErr | output | 1 | Response is an error |
| rspData | output | 64 | Read data, 0 for writes and errors |
| drainReq | output | 1 | Asks the pipeline to finish older work |
| pipeEmpty | input | 1 | Pipeline reports older work complete |
| issueHold | output | 1 | Blocks younger issue while a write is ordered |
| barrierPulse | output | 1 | One-cycle predictor barrier command |
| barrierAck | input | 1 | Predictor has completed the barrier |
| flushPulse | output | 1 | One-cycle data cache flush command |
| flushAck | input | 1 | Cache has completed the flush |
| ctrlBits | output | 3 | Persistent control register value |

## Verification
The assertions assume the neighbours behave. pipeEmpty only matters while a drain is requested. A command is acknowledged only after its pulse and before the next request. The configuration inputs change only while the unit is idle. The bench keeps to these rules. Its pipeline and acknowledge models respond only inside the request task, and only after they see drainReq or a pulse. It releases acknowledges and pipeEmpty once the response arrives. It alters featEn only between requests. Random requests mix legal and illegal indices, data and feature sets under a fixed seed. Directed cases cover reserved bits, absent features, zero command writes, slow acknowledges and requests offered while busy.

// File: rtl/spec_ctl_pkg.sv
package spec_ctl_pkg;

  localparam int DATA_W = 64;
  localparam int IDX_W  = 12;
  localparam int CTRL_W = 3;
  localparam int FEAT_N = 5;
  localparam int ID_W   = 32;

  // feature configuration slots
  localparam int F_BRANCH = 0;
  localparam int F_THREAD = 1;
  localparam int F_FLUSH  = 2;
  localparam int F_CAP    = 3;
  localparam int F_BYPASS = 4;

  localparam logic [IDX_W-1:0] IDX_CTRL    = 12'h048;
  localparam logic [IDX_W-1:0] IDX_BARRIER = 12'h049;
  localparam logic [IDX_W-1:0] IDX_CAP     = 12'h10A;
  localparam logic [IDX_W-1:0] IDX_FLUSH   = 12'h10B;

  typedef enum logic [1:0] {K_NONE, K_CTRL, K_BARRIER, K_FLUSH} kind_e;

  // strobes from the sequencer to the datapath
  typedef struct packed {
    logic latch;
    logic ctrlLoad;
    logic barrierFire;
    logic flushFire;
    logic respond;
    logic respErr;
    logic respRead;
  } strb_t;

  // feature slot reported at a given identification bit, -1 if none
  function automatic int featAt(int bitPos);
    case (bitPos)
      26:      return F_BRANCH;
      27:      return F_THREAD;
      28:      return F_FLUSH;
      29:      return F_CAP;
      31:      return F_BYPASS;
      default: return -1;
    endcase
  endfunction

  // feature slot that gates a control register bit
  function automatic int ctrlFeat(int b);
    case (b)
      0:       return F_BRANCH;
      1:       return F_THREAD;
      default: return F_BYPASS;
    endcase
  endfunction

endpackage

// File: rtl/spec_ctl_decode.sv
module spec_ctl_decode
  import spec_ctl_pkg::*;
#(
  parameter int DW = DATA_W,
  parameter int IW = IDX_W,
  parameter int CW = CTRL_W,
  parameter int FN = FEAT_N
) (
  input  logic          reqWrite,
  input  logic [IW-1:0] reqIndex,
  input  logic [DW-1:0] reqData,
  input  logic [FN-1:0] featEn,
  output kind_e         reqKind,
  output logic          reqErr,
  output logic          readCap,
  output logic          fireBit
);

  logic [CW-1:0] ctrlMask;
  logic [DW-1:0] ctrlAllow;
  logic [DW-1:0] cmdAllow;
  logic          ctrlBad;
  logic          cmdBad;
  logic          ctrlPresent;

  for (genvar b = 0; b < CW; b++) begin : g_mask
    assign ctrlMask[b] = featEn[ctrlFeat(b)];
  end

  assign ctrlAllow   = DW'(ctrlMask);
  assign cmdAllow    = DW'(1);
  assign ctrlBad     = |(reqData & ~ctrlAllow);
  assign cmdBad      = |(reqData & ~cmdAllow);
  assign ctrlPresent = |ctrlMask;
  assign fireBit     = reqData[0];

  always_comb begin
    reqKind = K_NONE;
    reqErr  = 1'b1;
    readCap = 1'b0;
    case (reqIndex)
      IDX_CTRL: begin
        reqKind = K_CTRL;
        reqErr  = !ctrlPresent || (reqWrite && ctrlBad);
      end
      IDX_BARRIER: begin
        reqKind = K_BARRIER;
        reqErr  = !reqWrite || !featEn[F_BRANCH] || cmdBad;
      end
      IDX_FLUSH: begin
        reqKind = K_FLUSH;
        reqErr  = !reqWrite || !featEn[F_FLUSH] || cmdBad;
      end
      IDX_CAP: begin
        readCap = 1'b1;
        reqErr  = reqWrite || !featEn[F_CAP];
      end
      default: begin
        reqKind = K_NONE;
        reqErr  = 1'b1;
      end
    endcase
  end

endmodule

// File: rtl/spec_ctl_seq.sv
module spec_ctl_seq
  import spec_ctl_pkg::*;
(
  input  logic  clk,
  input  logic  rstN,
  input  logic  reqValid,
  input  logic  reqWrite,
  input  kind_e reqKind,
  input  logic  reqErr,
  input  logic  fireBit,
  input  logic  pipeEmpty,
  input  logic  barrierAck,
  input  logic  flushAck,
  output logic  reqReady,
  output logic  drainReq,
  output logic  issueHold,
  output strb_t strb
);

  typedef enum logic [1:0] {S_IDLE, S_DRAIN, S_EXEC, S_WAIT} state_e;

  state_e state, stateNext;
  kind_e  pendKind;
  logic   pendFire;
  logic   ackNow;

  assign ackNow = (pendKind == K_BARRIER) ? barrierAck : flushAck;

  always_comb begin
    strb      = '0;
    stateNext = state;
    case (state)
      S_IDLE: begin
        if (reqValid) begin
          if (!reqWrite || reqErr) begin
            strb.respond  = 1'b1;
            strb.respErr  = reqErr;
            strb.respRead = !reqWrite && !reqErr;
          end else begin
            strb.latch = 1'b1;
            stateNext  = S_DRAIN;
          end
        end
      end
      S_DRAIN: begin
        if (pipeEmpty) stateNext = S_EXEC;
      end
      S_EXEC: begin
        case (pendKind)
          K_CTRL: begin
            strb.ctrlLoad = 1'b1;
            strb.respond  = 1'b1;
            stateNext     = S_IDLE;
          end
          K_BARRIER, K_FLUSH: begin
            if (pendFire) begin
              strb.barrierFire = (pendKind == K_BARRIER);
              strb.flushFire   = (pendKind == K_FLUSH);
              stateNext        = S_WAIT;
            end else begin
              strb.respond = 1'b1;
              stateNext    = S_IDLE;
            end
          end
          default: begin
            strb.respond = 1'b1;
            stateNext    = S_IDLE;
          end
        endcase
      end
      S_WAIT: begin
        if (ackNow) begin
          strb.respond = 1'b1;
          stateNext    = S_IDLE;
        end
      end
      default: stateNext = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= S_IDLE;
      pendKind <= K_NONE;
      pendFire <= 1'b0;
    end else begin
      state <= stateNext;
      if (strb.latch) begin
        pendKind <= reqKind;
        pendFire <= fireBit;
      end
    end
  end

  assign reqReady  = (state == S_IDLE);
  assign drainReq  = (state == S_DRAIN);
  assign issueHold = (state != S_IDLE);

endmodule

// File: rtl/spec_ctl_dpath.sv
module spec_ctl_dpath
  import spec_ctl_pkg::*;
#(
  parameter int DW = DATA_W,
  parameter int CW = CTRL_W,
  parameter int FN = FEAT_N,
  parameter int IDW = ID_W
) (
  input  logic           clk,
  input  logic           rstN,
  input  strb_t          strb,
  input  logic [CW-1:0]  wrBits,
  input  logic           readCap,
  input  logic [DW-1:0]  capWord,
  input  logic [FN-1:0]  featEn,
  output logic [CW-1:0]  ctrlBits,
  output logic           rspValid,
  output logic           rspErr,
  output logic [DW-1:0]  rspData,
  output logic           barrierPulse,
  output logic           flushPulse,
  output logic [IDW-1:0] idFeatWord
);

  logic [CW-1:0] ctrlReg;
  logic [CW-1:0] pendBits;
  logic [DW-1:0] rdVal;

  assign rdVal = readCap ? capWord : DW'(ctrlReg);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ctrlReg  <= '0;
      pendBits <= '0;
      rspValid <= 1'b0;
      rspErr   <= 1'b0;
      rspData  <= '0;
    end else begin
      if (strb.latch)    pendBits <= wrBits;
      if (strb.ctrlLoad) ctrlReg  <= pendBits;
      rspValid <= strb.respond;
      rspErr   <= strb.respond && strb.respErr;
      rspData  <= (strb.respond && strb.respRead) ? rdVal : '0;
    end
  end

  assign ctrlBits     = ctrlReg;
  assign barrierPulse = strb.barrierFire;
  assign flushPulse   = strb.flushFire;

  for (genvar g = 0; g < IDW; g++) begin : g_id
    if (featAt(g) >= 0) begin : g_on
      assign idFeatWord[g] = featEn[featAt(g)];
    end else begin : g_off
      assign idFeatWord[g] = 1'b0;
    end
  end

endmodule

// File: rtl/spec_ctl_unit.sv
module spec_ctl_unit
  import spec_ctl_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [FEAT_N-1:0] featEn,
  input  logic [DATA_W-1:0] capWord,
  output logic [ID_W-1:0]   idFeatWord,
  input  logic              reqValid,
  input  logic              reqWrite,
  input  logic [IDX_W-1:0]  reqIndex,
  input  logic [DATA_W-1:0] reqData,
  output logic              reqReady,
  output logic              rspValid,
  output logic              rspErr,
  output logic [DATA_W-1:0] rspData,
  output logic              drainReq,
  input  logic              pipeEmpty,
  output logic              issueHold,
  output logic              barrierPulse,
  input  logic              barrierAck,
  output logic              flushPulse,
  input  logic              flushAck,
  output logic [CTRL_W-1:0] ctrlBits
);

  kind_e reqKind;
  logic  reqErr;
  logic  readCap;
  logic  fireBit;
  strb_t strb;

  spec_ctl_decode #(
    .DW(DATA_W), .IW(IDX_W), .CW(CTRL_W), .FN(FEAT_N)
  ) dec_i (
    .reqWrite(reqWrite),
    .reqIndex(reqIndex),
    .reqData (reqData),
    .featEn  (featEn),
    .reqKind (reqKind),
    .reqErr  (reqErr),
    .readCap (readCap),
    .fireBit (fireBit)
  );

  spec_ctl_seq seq_i (
    .clk       (clk),
    .rstN      (rstN),
    .reqValid  (reqValid),
    .reqWrite  (reqWrite),
    .reqKind   (reqKind),
    .reqErr    (reqErr),
    .fireBit   (fireBit),
    .pipeEmpty (pipeEmpty),
    .barrierAck(barrierAck),
    .flushAck  (flushAck),
    .reqReady  (reqReady),
    .drainReq  (drainReq),
    .issueHold (issueHold),
    .strb      (strb)
  );

  spec_ctl_dpath #(
    .DW(DATA_W), .CW(CTRL_W), .FN(FEAT_N), .IDW(ID_W)
  ) dp_i (
    .clk         (clk),
    .rstN        (rstN),
    .strb        (strb),
    .wrBits      (reqData[CTRL_W-1:0]),
    .readCap     (readCap),
    .capWord     (capWord),
    .featEn      (featEn),
    .ctrlBits    (ctrlBits),
    .rspValid    (rspValid),
    .rspErr      (rspErr),
    .rspData     (rspData),
    .barrierPulse(barrierPulse),
    .flushPulse  (flushPulse),
    .idFeatWord  (idFeatWord)
  );

endmodule

// File: rtl/spec_ctl_chk.sv
module spec_ctl_chk
  import spec_ctl_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic              reqValid,
  input logic              reqWrite,
  input logic              reqReady,
  input logic              rspValid,
  input logic              rspErr,
  input logic              drainReq,
  input logic              pipeEmpty,
  input logic              issueHold,
  input logic              barrierPulse,
  input logic              flushPulse,
  input logic [CTRL_W-1:0] ctrlBits
);

  // R9
  barrier_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    barrierPulse |=> !barrierPulse);

  // R10
  flush_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    flushPulse |=> !flushPulse);

  // R7
  drain_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    drainReq |-> issueHold);

  // R7
  drain_cause_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(drainReq) |-> $past(reqValid && reqReady && reqWrite));

  // R8
  pulse_after_empty_chk: assert property (@(posedge clk) disable iff (!rstN)
    (barrierPulse || flushPulse) |-> $past(drainReq && pipeEmpty));

  // R5
  ctrl_change_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlBits != $past(ctrlBits)) |-> (rspValid && !rspErr));

  // R6
  err_stable_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && rspErr) |-> ($stable(ctrlBits) && !issueHold));

  // R12
  busy_ready_chk: assert property (@(posedge clk) disable iff (!rstN)
    issueHold |-> !reqReady);

  // R11
  one_cmd_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({barrierPulse, flushPulse}));

endmodule

bind spec_ctl_unit spec_ctl_chk chk_i (.*);

// File: tb/spec_ctl_unit_tb.sv
`timescale 1ns/1ps
module spec_ctl_unit_tb_top;
  import spec_ctl_pkg::*;

  logic        clk = 1'b0;
  logic        rstN;
  logic [4:0]  featEn;
  logic [63:0] capWord;
  logic [31:0] idFeatWord;
  logic        reqValid, reqWrite;
  logic [11:0] reqIndex;
  logic [63:0] reqData;
  logic        reqReady, rspValid, rspErr;
  logic [63:0] rspData;
  logic        drainReq, pipeEmpty, issueHold;
  logic        barrierPulse, barrierAck, flushPulse, flushAck;
  logic [2:0]  ctrlBits;

  int checks = 0;
  int errors = 0;
  bit finished = 0;
  logic [2:0] mCtrl = '0;

  always #2 clk = ~clk;

  spec_ctl_unit dut_i (.*);

  task automatic checkEq(string req, string what, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic endRun();
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  function automatic bit ctrlOn(logic [4:0] f);
    return f[0] | f[1] | f[4];
  endfunction

  function automatic bit expErr(bit w, logic [11:0] i, logic [63:0] d, logic [4:0] f);
    logic [63:0] allow;
    allow = {61'b0, f[4], f[1], f[0]};
    case (i)
      12'h048: return !ctrlOn(f) || (w && ((d & ~allow) != 64'b0));
      12'h049: return !w || !f[0] || (d[63:1] != 63'b0);
      12'h10B: return !w || !f[2] || (d[63:1] != 63'b0);
      12'h10A: return w || !f[3];
      default: return 1'b1;
    endcase
  endfunction

  function automatic logic [31:0] expFeat(logic [4:0] f);
    logic [31:0] v;
    v = '0;
    v[26] = f[0]; v[27] = f[1]; v[28] = f[2]; v[29] = f[3]; v[31] = f[4];
    return v;
  endfunction

  task automatic checkFeat();
    @(negedge clk);
    checkEq("R2", "idFeatWord", 64'(idFeatWord), 64'(expFeat(featEn)));
  endtask

  task automatic doReq(bit w, logic [11:0] idx, logic [63:0] d, int drainDly, int ackDly, bit poke);
    bit e, okWr, sawDrain, holdBad, early, gotEmpty, ackPend;
    int barN, flN, dcnt, acnt, guard;
    logic [2:0] ctrlBefore;
    logic [63:0] expData;
    string tag;
    e = expErr(w, idx, d, featEn);
    okWr = w && !e;
    sawDrain = 0; holdBad = 0; early = 0; gotEmpty = 0; ackPend = 0;
    barN = 0; flN = 0; dcnt = 0; acnt = 0; guard = 0;
    if (!w) tag = (idx == 12'h048 && !e) ? "R3" : "R4";
    else if (e) tag = "R6";
    else if (idx == 12'h048) tag = "R5";
    else if (!d[0]) tag = "R11";
    else tag = (idx == 12'h049) ? "R9" : "R10";
    expData = '0;
    if (!w && !e) expData = (idx == 12'h10A) ? capWord : {61'b0, mCtrl};

    @(negedge clk);
    ctrlBefore = ctrlBits;
    reqValid = 1'b1; reqWrite = w; reqIndex = idx; reqData = d;
    @(negedge clk);
    reqValid = 1'b0;
    if (poke && okWr) begin
      reqValid = 1'b1; reqWrite = 1'b1; reqIndex = 12'h048; reqData = 64'h7;
    end
    while (!rspValid && guard < 100) begin
      guard++;
      if (!issueHold) holdBad = 1;
      if (drainReq) sawDrain = 1;
      if ((barrierPulse || flushPulse || ctrlBits !== ctrlBefore) && !gotEmpty) early = 1;
      if (barrierPulse) begin barN++; ackPend = 1; acnt = 0; end
      if (flushPulse) begin flN++; ackPend = 1; acnt = 0; end
      if (ackPend && !barrierPulse && !flushPulse) begin
        if (acnt >= ackDly) begin
          if (idx == 12'h049) barrierAck = 1'b1; else flushAck = 1'b1;
          ackPend = 0;
        end else acnt++;
      end
      if (drainReq && !pipeEmpty) begin
        if (dcnt >= drainDly) begin
          pipeEmpty = 1'b1; gotEmpty = 1; reqValid = 1'b0;
        end else dcnt++;
      end
      @(negedge clk);
    end
    checkEq(tag, "response seen", 64'(rspValid), 64'd1);
    checkEq(tag, "rspErr", 64'(rspErr), 64'(e));
    checkEq(tag, "rspData", rspData, expData);
    if (okWr && idx == 12'h048) mCtrl = d[2:0];
    checkEq(tag, "ctrlBits", 64'(ctrlBits), 64'(mCtrl));
    checkEq("R7", "drain raised", 64'(sawDrain), 64'(okWr));
    checkEq("R7", "hold held", 64'(holdBad), 64'd0);
    checkEq("R7", "hold released", 64'(issueHold), 64'd0);
    checkEq("R7", "ready at response", 64'(reqReady), 64'd1);
    checkEq("R8", "effect before empty", 64'(early), 64'd0);
    checkEq((!okWr || d[0]) ? "R9" : "R11", "barrier pulses", 64'(barN),
            64'(okWr && idx == 12'h049 && d[0]));
    checkEq((!okWr || d[0]) ? "R10" : "R11", "flush pulses", 64'(flN),
            64'(okWr && idx == 12'h10B && d[0]));
    pipeEmpty = 1'b0; barrierAck = 1'b0; flushAck = 1'b0; reqValid = 1'b0;
    if (poke) begin
      for (int k = 0; k < 3; k++) begin
        @(negedge clk);
        checkEq("R12", "no extra response", 64'(rspValid), 64'd0);
        checkEq("R12", "ctrl untouched", 64'(ctrlBits), 64'(mCtrl));
      end
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog expired actual=running expected=done");
      endRun();
    end
  end

  initial begin
    void'($urandom(32'd4711));
    rstN = 1'b0; featEn = 5'b11111; capWord = 64'hA5C3_0000_0001_00F0;
    reqValid = 1'b0; reqWrite = 1'b0; reqIndex = '0; reqData = '0;
    pipeEmpty = 1'b0; barrierAck = 1'b0; flushAck = 1'b0;
    repeat (4) @(posedge clk);
    @(negedge clk) rstN = 1'b1;
    @(negedge clk);
    checkEq("R1", "ctrlBits", 64'(ctrlBits), 64'd0);
    checkEq("R1", "reqReady", 64'(reqReady), 64'd1);
    checkEq("R1", "idle outputs", 64'({rspValid, drainReq, issueHold, barrierPulse, flushPulse}), 64'd0);
    checkFeat();

    // directed corner cases
    doReq(1, 12'h048, 64'h7, 2, 0, 0);
    doReq(0, 12'h048, 64'h0, 0, 0, 0);
    doReq(0, 12'h10A, 64'h0, 0, 0, 0);
    doReq(1, 12'h10A, 64'h1, 0, 0, 0);
    doReq(1, 12'h048, 64'h8, 0, 0, 0);
    doReq(0, 12'h049, 64'h0, 0, 0, 0);
    doReq(0, 12'h10B, 64'h0, 0, 0, 0);
    doReq(1, 12'h049, 64'h3, 0, 0, 0);
    doReq(1, 12'h123, 64'h1, 0, 0, 0);
    featEn = 5'b00001; checkFeat();
    doReq(1, 12'h048, 64'h2, 0, 0, 0);
    doReq(1, 12'h048, 64'h1, 1, 0, 0);
    doReq(1, 12'h049, 64'h1, 3, 2, 0);
    doReq(1, 12'h10B, 64'h1, 0, 0, 0);
    doReq(0, 12'h10A, 64'h0, 0, 0, 0);
    featEn = 5'b11111; checkFeat();
    doReq(1, 12'h10B, 64'h1, 1, 5, 0);
    doReq(1, 12'h049, 64'h0, 0, 0, 0);
    doReq(1, 12'h10B, 64'h0, 2, 0, 0);
    doReq(1, 12'h048, 64'h4, 4, 0, 1);
    featEn = 5'b00000; checkFeat();
    doReq(0, 12'h048, 64'h0, 0, 0, 0);
    doReq(1, 12'h048, 64'h0, 0, 0, 0);

    // constrained random traffic
    for (int n = 0; n < 250; n++) begin
      int pick;
      logic [11:0] idx;
      logic [63:0] d;
      if (n % 20 == 0) begin
        featEn = 5'($urandom);
        checkFeat();
      end
      pick = int'($urandom % 6);
      case (pick)
        0, 5: idx = 12'h048;
        1: idx = 12'h049;
        2: idx = 12'h10A;
        3: idx = 12'h10B;
        default: idx = 12'($urandom);
      endcase
      if ($urandom % 8 == 0) d = {32'($urandom), 32'($urandom)};
      else if (idx == 12'h048) d = 64'($urandom % 8);
      else d = 64'($urandom % 2);
      doReq(($urandom % 4) != 0, idx, d, int'($urandom % 4), int'($urandom % 4), 0);
    end
    endRun();
  end

endmodule